// File: doc/BRIEF.md
# I2C Master Byte Transmitter

This block is the transmit half of an I2C master. It sends one byte, either an address with its direction bit or a data byte, and then reads back the slave's acknowledge. The bus is assumed to be already owned by the master, so SCL is held low when the block is idle. Writing a byte into the block starts a transfer. The block shifts eight bits out most significant bit first. It then lets go of SDA for a ninth clock pulse, during which the slave answers.

The bit timing comes from a down-counter that reloads from a value captured at the moment the byte is written. Each SCL half-period lasts reload+1 system clocks. After the ninth pulse the block stores the acknowledge result, raises an interrupt flag and stops the clock with SCL low. It then waits for the next byte. A write that arrives while a byte is still being shifted is refused, and a collision flag records it. Both flags stay set until the CPU side clears them. Both bus lines are open-drain, so the block only produces drive-low enables and reads SDA back through an input.

Top module: `i2c_byte_tx`

## Requirements
- R1: After reset: scl_drive_low=1, sda_drive_low=0, busy=0, buf_full=0, irq=0, wcol=0 and ack_stat=0.
- R2: When wr_en is high and busy is low, the transfer starts on that clock edge:
  - From the next cycle, busy=1 and buf_full=1.
  - The value on reload is captured for the whole transfer.
- R3: The byte on wr_data is sent most significant bit first. While a bit is on the bus, sda_drive_low is the inverse of that bit. sda_drive_low changes only while SCL is driven low.
- R4: A transfer has exactly nine SCL pulses:
  - Every low phase lasts reload+1 clocks, counting from the first cycle after the write.
  - Every high phase (scl_drive_low=0) also lasts reload+1 clocks.
- R5: On the eighth falling edge of SCL, buf_full returns to 0 and the master stops driving SDA low, leaving SDA free for the ninth pulse.
- R6: The block samples sda_in at the end of the ninth high phase and stores it in ack_stat on the ninth falling edge:
  - ack_stat=0 means the slave held SDA low (acknowledge).
  - ack_stat=1 means SDA was high (no acknowledge).
- R7: After the ninth falling edge:
  - irq=1 and busy=0.
  - SCL stays driven low and SDA stays released.
  - No further SCL pulse occurs until the next accepted write.
- R8: irq stays at 1 until a clr_irq pulse clears it. When irq is being set and clr_irq is high in the same cycle, setting wins.
- R9: A write while busy=1 is refused. It sets wcol, and the byte being sent does not change.
- R10: wcol stays at 1 until a clr_col pulse clears it. Later accepted writes do not clear it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reload | input | DIV_W | Half-period reload value, captured on an accepted write |
| wr_en | input | 1 | Byte write strobe |
| wr_data | input | 8 | Byte to send |
| clr_irq | input | 1 | Clears irq |
| clr_col | input | 1 | Clears wcol |
| sda_in | input | 1 | Sampled level of the SDA line |
| scl_drive_low | output | 1 | Pull SCL low when 1 |
| sda_drive_low | output | 1 | Pull SDA low when 1 |
| busy | output | 1 | A byte is being shifted or acknowledged |
| buf_full | output | 1 | Transmit byte not yet fully shifted out |
| ack_stat | output | 1 | Stored acknowledge result |
| irq | output | 1 | Byte-complete interrupt flag |
| wcol | output | 1 | Write-collision flag |

## Verification
The bench sends every byte value at the smallest reload, and a spread of bytes at larger reloads. It times every SCL half-period, so an off-by-one in the reload count shows up as phases of reload or reload+2 clocks. It also catches a design that drops or adds a pulse. A slave model acknowledges one address only. A design that samples SDA at the wrong moment, or inverts the sense of the acknowledge, therefore reports the wrong ack_stat. A design that does not release SDA at the eighth falling edge produces a false acknowledge. The bench injects a write mid-transfer and checks the bits that follow, which catches a design that lets the colliding write corrupt the byte in flight. It also leaves the flags uncleared across idle time and later writes, which catches a flag that clears itself.

// File: rtl/i2c_byte_tx.sv
module i2c_byte_tx #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] reload,
  input  logic             wr_en,
  input  logic [7:0]       wr_data,
  input  logic             clr_irq,
  input  logic             clr_col,
  input  logic             sda_in,
  output logic             scl_drive_low,
  output logic             sda_drive_low,
  output logic             busy,
  output logic             buf_full,
  output logic             ack_stat,
  output logic             irq,
  output logic             wcol
);

  localparam int BITS = 8;
  localparam int BCW  = $clog2(BITS + 1);

  logic [DIV_W-1:0] rld, cnt;
  logic [BCW-1:0]   bit_cnt;
  logic [7:0]       shreg;
  logic             scl_hi;

  wire accept   = wr_en && !busy;
  wire rollover = busy && (cnt == '0);
  wire fall     = rollover && scl_hi;
  wire last     = (bit_cnt == BCW'(BITS));

  assign scl_drive_low = !scl_hi;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rld <= '0;
      cnt <= '0;
      bit_cnt <= '0;
      shreg <= '0;
      scl_hi <= 1'b0;
      sda_drive_low <= 1'b0;
      busy <= 1'b0;
      buf_full <= 1'b0;
      ack_stat <= 1'b0;
    end else if (accept) begin
      rld <= reload;
      cnt <= reload;
      bit_cnt <= '0;
      shreg <= wr_data;
      scl_hi <= 1'b0;
      sda_drive_low <= ~wr_data[7];
      busy <= 1'b1;
      buf_full <= 1'b1;
    end else if (busy) begin
      if (cnt != '0) begin
        cnt <= cnt - 1'b1;
      end else begin
        cnt <= rld;
        if (!scl_hi) begin
          scl_hi <= 1'b1;
        end else begin
          scl_hi <= 1'b0;
          if (last) begin
            busy <= 1'b0;
            ack_stat <= sda_in;
          end else begin
            bit_cnt <= bit_cnt + 1'b1;
            shreg <= {shreg[6:0], 1'b0};
            if (bit_cnt == BCW'(BITS - 1)) begin
              buf_full <= 1'b0;
              sda_drive_low <= 1'b0;
            end else begin
              sda_drive_low <= ~shreg[6];
            end
          end
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq <= 1'b0;
      wcol <= 1'b0;
    end else begin
      if (fall && last)  irq <= 1'b1;
      else if (clr_irq)  irq <= 1'b0;
      if (wr_en && busy) wcol <= 1'b1;
      else if (clr_col)  wcol <= 1'b0;
    end
  end

endmodule

module i2c_byte_tx_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       wr_en,
  input logic       clr_irq,
  input logic       clr_col,
  input logic       busy,
  input logic       buf_full,
  input logic       irq,
  input logic       wcol,
  input logic       scl_drive_low,
  input logic       sda_drive_low,
  input logic [3:0] bit_cnt
);

  p_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !busy) |=> (busy && buf_full));

  p_sda_quiet_high_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!scl_drive_low && !$past(scl_drive_low)) |-> $stable(sda_drive_low));

  p_ack_release_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && bit_cnt == 4'd8) |-> (!sda_drive_low && !buf_full));

  p_idle_scl_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (scl_drive_low && !buf_full));

  p_irq_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !clr_irq) |=> irq);

  p_collide_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && busy) |=> wcol);

  p_col_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (wcol && !clr_col) |=> wcol);

endmodule

bind i2c_byte_tx i2c_byte_tx_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .clr_irq(clr_irq), .clr_col(clr_col),
  .busy(busy), .buf_full(buf_full), .irq(irq), .wcol(wcol),
  .scl_drive_low(scl_drive_low), .sda_drive_low(sda_drive_low), .bit_cnt(bit_cnt)
);

// File: tb/sim_i2c_byte_tx.sv
`timescale 1ns/1ps
module sim_i2c_byte_tx;
  localparam logic [7:0] ACK_ADDR = 8'hA4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [7:0] reload = '0;
  logic wr_en = 1'b0, clr_irq = 1'b0, clr_col = 1'b0;
  logic [7:0] wr_data = '0;
  logic sda_in;
  logic scl_drive_low, sda_drive_low, busy, buf_full, ack_stat, irq, wcol;

  int checks = 0, fails = 0;
  int falls = 0;
  logic [7:0] got = '0;
  logic ack_window = 1'b0;
  wire slave_pull = ack_window && (falls == 8) && (got == ACK_ADDR);
  assign sda_in = !(sda_drive_low || slave_pull);

  always #2.5 clk = ~clk;

  i2c_byte_tx u0 (
    .clk(clk), .rst_n(rst_n), .reload(reload), .wr_en(wr_en), .wr_data(wr_data),
    .clr_irq(clr_irq), .clr_col(clr_col), .sda_in(sda_in),
    .scl_drive_low(scl_drive_low), .sda_drive_low(sda_drive_low), .busy(busy),
    .buf_full(buf_full), .ack_stat(ack_stat), .irq(irq), .wcol(wcol)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic xfer(input logic [7:0] b, input int r, input bit do_col, input logic [7:0] colv);
    int cnt, rises, guard;
    logic prev, cur, prev_sda, line;
    @(negedge clk);
    reload = r[7:0]; wr_data = b; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; reload = 8'hFF; wr_data = ~b;
    chk(busy && buf_full, "R2 start", {busy, buf_full}, 3);
    chk(scl_drive_low, "R4 first low", scl_drive_low, 1);
    chk(sda_drive_low == ~b[7], "R3 first bit", sda_drive_low, ~b[7]);
    falls = 0; got = '0; ack_window = 1'b1;
    cnt = 1; rises = 0; guard = 0; prev = 1'b0; prev_sda = sda_drive_low;
    forever begin
      @(negedge clk);
      guard++;
      if (do_col && guard == 3) begin wr_en = 1'b1; wr_data = colv; end
      if (do_col && guard == 4) begin
        wr_en = 1'b0;
        chk(wcol, "R9 collision flag", wcol, 1);
      end
      cur = !scl_drive_low;
      line = sda_in;
      if (cur == prev) begin
        cnt++;
        if (cur && sda_drive_low != prev_sda) chk(0, "R3 sda moved while scl high", sda_drive_low, prev_sda);
      end else begin
        chk(cnt == r + 1, cur ? "R4 low phase" : "R4 high phase", cnt, r + 1);
        if (cur) begin
          rises++;
          if (rises <= 8) got = {got[6:0], line};
        end else begin
          falls++;
          if (falls == 1) chk(buf_full, "R5 buf_full held", buf_full, 1);
          if (falls == 8) chk(!buf_full && !sda_drive_low, "R5 release at 8th fall",
                              {buf_full, sda_drive_low}, 0);
        end
        cnt = 1;
      end
      prev_sda = sda_drive_low;
      prev = cur;
      if (!busy || guard > 5000) break;
    end
    ack_window = 1'b0;
    chk(rises == 9 && falls == 9, "R4 pulse count", rises, 9);
    chk(got == b, do_col ? "R9 byte unchanged" : "R3 byte MSB first", got, b);
    chk(ack_stat == (b != ACK_ADDR), "R6 ack status", ack_stat, b != ACK_ADDR);
    chk(irq && !busy && scl_drive_low && !sda_drive_low, "R7 end state",
        {irq, busy, scl_drive_low, sda_drive_low}, 4'b1010);
  endtask

  task automatic clear_irq();
    @(negedge clk); clr_irq = 1'b1;
    @(negedge clk); clr_irq = 1'b0;
    chk(!irq, "R8 clr_irq clears", irq, 0);
  endtask

  initial begin
    int cyc = 0;
    forever begin
      @(posedge clk); cyc++;
      if (cyc > 190000) begin
        fails++; checks++;
        $display("FAIL watchdog actual=%0d expected<190000", cyc);
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
      end
    end
  end

  initial begin
    #12 rst_n = 1'b1;
    @(negedge clk);
    chk(scl_drive_low && !sda_drive_low && !busy && !buf_full && !irq && !wcol && !ack_stat,
        "R1 reset state", {scl_drive_low, sda_drive_low, busy, buf_full, irq, wcol, ack_stat}, 7'h40);

    for (int v = 0; v < 256; v++) begin
      xfer(v[7:0], 0, 1'b0, 8'h00);
      clear_irq();
    end
    for (int r = 1; r < 4; r++)
      for (int k = 0; k < 12; k++) begin
        xfer(k[7:0] * 8'd37 + 8'h5A, r, 1'b0, 8'h00);
        clear_irq();
      end
    xfer(ACK_ADDR, 2, 1'b0, 8'h00);
    clear_irq();

    xfer(8'hC3, 1, 1'b0, 8'h00);
    repeat (20) begin
      @(negedge clk);
      chk(irq, "R8 irq sticky", irq, 1);
      chk(scl_drive_low, "R7 clock stopped", scl_drive_low, 1);
    end
    clear_irq();

    xfer(8'h3C, 2, 1'b1, 8'hFF);
    repeat (10) @(negedge clk);
    chk(wcol, "R10 wcol sticky idle", wcol, 1);
    clear_irq();
    xfer(ACK_ADDR, 0, 1'b0, 8'h00);
    chk(wcol, "R10 wcol survives accepted write", wcol, 1);
    clear_irq();
    @(negedge clk); clr_col = 1'b1;
    @(negedge clk); clr_col = 1'b0;
    chk(!wcol, "R10 clr_col clears", wcol, 0);

    xfer(8'h81, 3, 1'b1, 8'h00);
    clear_irq();

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule